// File: doc/BRIEF.md
# SDRAM Command Spacing Gate

This block sits between an SDRAM command scheduler and the memory pins. Each clock, the scheduler presents one requested command with a bank number. The block answers with a combinational `ready` that is high only when issuing that command now would break no spacing rule. A command is issued on a clock edge where `req_valid` and `ready` are both high. A request that is not ready stays with the scheduler and is never dropped. The block also raises a per-bank flag when an open row nears its maximum open time.

Spacing limits are parameters. Limits given in nanoseconds are divided by the clock period (`TCK_PS`, picoseconds) and rounded up to whole clocks at elaboration. Write-recovery gaps are given directly in clocks. Each bank keeps a small state machine with two states, `BK_IDLE` and `BK_OPEN`:
- `BK_IDLE` goes to `BK_OPEN` on an issued ACTIVE.
- `BK_OPEN` goes to `BK_IDLE` on an issued PRECHARGE.
- Every other command leaves the state unchanged.

Alongside the state machine, each bank has down-counters that are reloaded by its own commands, plus an up-counter for row age. A few counters are shared by all banks.

Command codes on `req_cmd` are: NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, AUTO REFRESH=5, BURST STOP=6. Code 7 is never ready.

Top module: `sdram_cmd_gate`

## Requirements
- R1: Each nanosecond limit becomes N = ceil(ns*1000 / TCK_PS) clocks. A rule with N clocks allows the next command at the earliest N cycles after the command that started the gap.
- R2: ACTIVE (code 1) is ready only under all of these conditions:
  - the bank is `BK_IDLE`;
  - at least tRP clocks have passed since the last PRECHARGE of that bank;
  - at least tRC clocks have passed since the last ACTIVE of that bank;
  - at least tRRD clocks have passed since the last ACTIVE to any bank.
- R3: READ (code 2) and WRITE (code 3) are ready only under all of these conditions:
  - the bank is `BK_OPEN`;
  - at least tRCD clocks have passed since that bank's ACTIVE;
  - at least TCDL_CK clocks have passed since the last WRITE to any bank.

  With no pending write gap, column commands may issue every clock.
- R4: PRECHARGE (code 4) is ready only when at least tRAS(min) clocks have passed since that bank's ACTIVE and at least TRDL_CK clocks have passed since that bank's last WRITE.
- R5: AUTO REFRESH (code 5) is ready only when every bank is `BK_IDLE` and every bank's tRP gap has elapsed.
- R6: BURST STOP (code 6) is ready only when at least TBDL_CK clocks have passed since the last WRITE.
- R7: NOP (code 0) is always ready. For every command, `ready` depends only on `req_cmd`, `req_bank` and stored state, never on `req_valid`.
- R8: `row_age_warn[b]` is high while bank b is open and at least ceil(TRAS_MAX_NS*1000/TCK_PS) − WARN_CK clocks have passed since its ACTIVE. It drops once the bank is precharged.
- R9: After reset every bank is `BK_IDLE`, all gaps have elapsed and no warning is raised.
- R10: An issued PRECHARGE closes the bank, so READ/WRITE to that bank is not ready until a new ACTIVE. A PRECHARGE to an idle bank leaves it idle.
- R11: For tRFC clocks after an issued AUTO REFRESH, every command other than NOP is not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Scheduler wants to issue `req_cmd` this cycle |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | $clog2(NBANK) | Target bank of the request |
| ready | output | 1 | Request may issue this cycle without breaking a rule |
| row_age_warn | output | NBANK | Per-bank flag: open row nears its maximum open time |

## Verification
The bench builds the block with a 7.5 ns period. This gives multi-clock gaps for tRRD (2), tRCD and tRP (3), tRAS (6), and tRC and tRFC (8), so each spacing boundary falls on a distinct cycle. The bench also shortens the maximum open time to 300 ns with a 4-clock warning margin, so the age flag rises after 36 clocks instead of thousands. It widens the write gaps to 2, 3 and 2 clocks, which lets the column, precharge and burst-stop write recovery be seen separately from the back-to-back default. A random command stream is compared every cycle against a timestamp model of all rules.

// File: rtl/sdram_gate_pkg.sv
`timescale 1ns/1ps
package sdram_gate_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_BST = 3'd6
    } cmd_e;

    typedef enum logic {
        BK_IDLE = 1'b0,
        BK_OPEN = 1'b1
    } bank_state_e;

    // Nanoseconds to whole clocks, rounding up (R1)
    function automatic int ns2clk(input int ns, input int tck_ps);
        return (ns * 1000 + tck_ps - 1) / tck_ps;
    endfunction

    // Counter reload value for a gap of n clocks
    function automatic int gap_load(input int n);
        return (n > 0) ? n - 1 : 0;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_dncnt.sv
`timescale 1ns/1ps
module sdram_dncnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sdram_bank_timer.sv
`timescale 1ns/1ps
module sdram_bank_timer
    import sdram_gate_pkg::*;
#(
    parameter int CW       = 4,
    parameter int AW       = 8,
    parameter int RCD_CK   = 3,
    parameter int RP_CK    = 3,
    parameter int RC_CK    = 8,
    parameter int RAS_CK   = 6,
    parameter int RDL_CK   = 2,
    parameter int AGE_MAX  = 100,
    parameter int AGE_WARN = 90
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_go,
    input  logic wr_go,
    input  logic pre_go,
    output logic is_open,
    output logic rcd_ok,
    output logic rp_ok,
    output logic rc_ok,
    output logic ras_ok,
    output logic rdl_ok,
    output logic age_warn
);
    localparam logic [CW-1:0] L_RCD = CW'(gap_load(RCD_CK));
    localparam logic [CW-1:0] L_RP  = CW'(gap_load(RP_CK));
    localparam logic [CW-1:0] L_RC  = CW'(gap_load(RC_CK));
    localparam logic [CW-1:0] L_RAS = CW'(gap_load(RAS_CK));
    localparam logic [CW-1:0] L_RDL = CW'(gap_load(RDL_CK));
    localparam logic [AW-1:0] AGE_TOP  = AW'(AGE_MAX);
    localparam logic [AW-1:0] AGE_FLAG = AW'(AGE_WARN);

    bank_state_e state, state_nx;
    logic [AW-1:0] age;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= BK_IDLE;
        else        state <= state_nx;
    end

    // Transitions: IDLE -> OPEN on ACTIVE, OPEN -> IDLE on PRECHARGE
    always_comb begin
        state_nx = state;
        unique case (state)
            BK_IDLE: if (act_go) state_nx = BK_OPEN;
            BK_OPEN: if (pre_go) state_nx = BK_IDLE;
        endcase
    end

    // Row age since ACTIVE, saturating at the maximum open time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (act_go) begin
            age <= AW'(1);
        end else if (pre_go) begin
            age <= '0;
        end else if (state == BK_OPEN && age != AGE_TOP) begin
            age <= age + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        is_open  = (state == BK_OPEN);
        age_warn = is_open && (age >= AGE_FLAG);
    end

    sdram_dncnt #(.W(CW)) u_rcd (.clk(clk), .rst_n(rst_n), .load(act_go), .load_val(L_RCD), .done(rcd_ok));
    sdram_dncnt #(.W(CW)) u_rp  (.clk(clk), .rst_n(rst_n), .load(pre_go), .load_val(L_RP),  .done(rp_ok));
    sdram_dncnt #(.W(CW)) u_rc  (.clk(clk), .rst_n(rst_n), .load(act_go), .load_val(L_RC),  .done(rc_ok));
    sdram_dncnt #(.W(CW)) u_ras (.clk(clk), .rst_n(rst_n), .load(act_go), .load_val(L_RAS), .done(ras_ok));
    sdram_dncnt #(.W(CW)) u_rdl (.clk(clk), .rst_n(rst_n), .load(wr_go),  .load_val(L_RDL), .done(rdl_ok));
endmodule

// File: rtl/sdram_global_timer.sv
`timescale 1ns/1ps
module sdram_global_timer
    import sdram_gate_pkg::*;
#(
    parameter int CW     = 4,
    parameter int RRD_CK = 2,
    parameter int RFC_CK = 8,
    parameter int CDL_CK = 1,
    parameter int BDL_CK = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_any,
    input  logic wr_any,
    input  logic ref_go,
    output logic rrd_ok,
    output logic rfc_ok,
    output logic cdl_ok,
    output logic bdl_ok
);
    localparam logic [CW-1:0] L_RRD = CW'(gap_load(RRD_CK));
    localparam logic [CW-1:0] L_RFC = CW'(gap_load(RFC_CK));
    localparam logic [CW-1:0] L_CDL = CW'(gap_load(CDL_CK));
    localparam logic [CW-1:0] L_BDL = CW'(gap_load(BDL_CK));

    sdram_dncnt #(.W(CW)) u_rrd (.clk(clk), .rst_n(rst_n), .load(act_any), .load_val(L_RRD), .done(rrd_ok));
    sdram_dncnt #(.W(CW)) u_rfc (.clk(clk), .rst_n(rst_n), .load(ref_go),  .load_val(L_RFC), .done(rfc_ok));
    sdram_dncnt #(.W(CW)) u_cdl (.clk(clk), .rst_n(rst_n), .load(wr_any),  .load_val(L_CDL), .done(cdl_ok));
    sdram_dncnt #(.W(CW)) u_bdl (.clk(clk), .rst_n(rst_n), .load(wr_any),  .load_val(L_BDL), .done(bdl_ok));
endmodule

// File: rtl/sdram_cmd_gate.sv
`timescale 1ns/1ps
module sdram_cmd_gate
    import sdram_gate_pkg::*;
#(
    parameter int NBANK       = 4,
    parameter int TCK_PS      = 7500,
    parameter int TRRD_NS     = 12,
    parameter int TRCD_NS     = 18,
    parameter int TRP_NS      = 18,
    parameter int TRC_NS      = 60,
    parameter int TRAS_NS     = 42,
    parameter int TRAS_MAX_NS = 100000,
    parameter int TRFC_NS     = 60,
    parameter int TCDL_CK     = 1,
    parameter int TRDL_CK     = 2,
    parameter int TBDL_CK     = 1,
    parameter int WARN_CK     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_cmd,
    input  logic [$clog2(NBANK)-1:0] req_bank,
    output logic                     ready,
    output logic [NBANK-1:0]         row_age_warn
);
    localparam int BW      = $clog2(NBANK);
    localparam int RRD_CK  = ns2clk(TRRD_NS, TCK_PS);
    localparam int RCD_CK  = ns2clk(TRCD_NS, TCK_PS);
    localparam int RP_CK   = ns2clk(TRP_NS, TCK_PS);
    localparam int RC_CK   = ns2clk(TRC_NS, TCK_PS);
    localparam int RAS_CK  = ns2clk(TRAS_NS, TCK_PS);
    localparam int RFC_CK  = ns2clk(TRFC_NS, TCK_PS);
    localparam int AGE_MAX = ns2clk(TRAS_MAX_NS, TCK_PS);
    localparam int AGE_WARN = (AGE_MAX > WARN_CK) ? AGE_MAX - WARN_CK : 0;
    localparam int GAP_MAX = max2(max2(max2(RRD_CK, RCD_CK), max2(RP_CK, RC_CK)),
                                  max2(max2(RAS_CK, RFC_CK),
                                       max2(max2(TCDL_CK, TRDL_CK), max2(TBDL_CK, 1))));
    localparam int CW      = $clog2(GAP_MAX + 1);
    localparam int AW      = $clog2(AGE_MAX + 1);

    logic issue;
    logic act_any, wr_any, ref_go;
    logic [NBANK-1:0] act_go, wr_go, pre_go;
    logic [NBANK-1:0] bk_open, bk_rcd_ok, bk_rp_ok, bk_rc_ok, bk_ras_ok, bk_rdl_ok;
    logic rrd_ok, rfc_ok, cdl_ok, bdl_ok;
    logic all_idle;

    assign issue   = req_valid && ready;
    assign act_any = issue && (req_cmd == CMD_ACT);
    assign wr_any  = issue && (req_cmd == CMD_WR);
    assign ref_go  = issue && (req_cmd == CMD_REF);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit       = issue && (req_bank == BW'(b));
        assign act_go[b] = hit && (req_cmd == CMD_ACT);
        assign wr_go[b]  = hit && (req_cmd == CMD_WR);
        assign pre_go[b] = hit && (req_cmd == CMD_PRE);

        sdram_bank_timer #(
            .CW(CW), .AW(AW),
            .RCD_CK(RCD_CK), .RP_CK(RP_CK), .RC_CK(RC_CK),
            .RAS_CK(RAS_CK), .RDL_CK(TRDL_CK),
            .AGE_MAX(AGE_MAX), .AGE_WARN(AGE_WARN)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .act_go(act_go[b]), .wr_go(wr_go[b]), .pre_go(pre_go[b]),
            .is_open(bk_open[b]), .rcd_ok(bk_rcd_ok[b]), .rp_ok(bk_rp_ok[b]),
            .rc_ok(bk_rc_ok[b]), .ras_ok(bk_ras_ok[b]), .rdl_ok(bk_rdl_ok[b]),
            .age_warn(row_age_warn[b])
        );
    end

    sdram_global_timer #(
        .CW(CW), .RRD_CK(RRD_CK), .RFC_CK(RFC_CK),
        .CDL_CK(TCDL_CK), .BDL_CK(TBDL_CK)
    ) u_glob (
        .clk(clk), .rst_n(rst_n),
        .act_any(act_any), .wr_any(wr_any), .ref_go(ref_go),
        .rrd_ok(rrd_ok), .rfc_ok(rfc_ok), .cdl_ok(cdl_ok), .bdl_ok(bdl_ok)
    );

    assign all_idle = ((~bk_open & bk_rp_ok) == {NBANK{1'b1}});

    // Readiness: a function of the request and the counter state only
    always_comb begin
        ready = 1'b0;
        unique case (req_cmd)
            CMD_NOP: ready = 1'b1;
            CMD_ACT: ready = !bk_open[req_bank] && bk_rp_ok[req_bank] &&
                             bk_rc_ok[req_bank] && rrd_ok && rfc_ok;
            CMD_RD,
            CMD_WR:  ready = bk_open[req_bank] && bk_rcd_ok[req_bank] &&
                             cdl_ok && rfc_ok;
            CMD_PRE: ready = bk_ras_ok[req_bank] && bk_rdl_ok[req_bank] && rfc_ok;
            CMD_REF: ready = all_idle && rfc_ok;
            CMD_BST: ready = bdl_ok && rfc_ok;
            default: ready = 1'b0;
        endcase
    end
endmodule

// File: rtl/sdram_cmd_gate_chk.sv
`timescale 1ns/1ps
module sdram_cmd_gate_chk
    import sdram_gate_pkg::*;
#(
    parameter int NBANK   = 4,
    parameter int TCK_PS  = 7500,
    parameter int TRRD_NS = 12,
    parameter int TRFC_NS = 60,
    parameter int TRDL_CK = 2,
    parameter int TBDL_CK = 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [2:0]               req_cmd,
    input logic [$clog2(NBANK)-1:0] req_bank,
    input logic                     ready,
    input logic [NBANK-1:0]         row_age_warn
);
    localparam int RRD_CK = ns2clk(TRRD_NS, TCK_PS);
    localparam int RFC_CK = ns2clk(TRFC_NS, TCK_PS);

    logic iss;
    logic [NBANK-1:0] sh_open;

    assign iss = req_valid && ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_open <= '0;
        end else if (iss && req_cmd == CMD_ACT) begin
            sh_open[req_bank] <= 1'b1;
        end else if (iss && req_cmd == CMD_PRE) begin
            sh_open[req_bank] <= 1'b0;
        end
    end

    a_r7_nop_ready: assert property (@(posedge clk) disable iff (!rst_n)
        req_cmd == CMD_NOP |-> ready);

    a_r2_act_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (iss && req_cmd == CMD_ACT) |-> !sh_open[req_bank]);

    a_r3_col_open: assert property (@(posedge clk) disable iff (!rst_n)
        (iss && (req_cmd == CMD_RD || req_cmd == CMD_WR)) |-> sh_open[req_bank]);

    a_r5_ref_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (iss && req_cmd == CMD_REF) |-> (sh_open == '0));

    a_r10_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (iss && req_cmd == CMD_PRE) |=> !row_age_warn[$past(req_bank)]);

    if (RRD_CK >= 2) begin : g_rrd
        a_r2_rrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (iss && req_cmd == CMD_ACT) |=> !(iss && req_cmd == CMD_ACT));
    end

    if (RFC_CK >= 2) begin : g_rfc
        a_r11_rfc_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (iss && req_cmd == CMD_REF) |=> !(iss && req_cmd != CMD_NOP));
    end

    if (TRDL_CK >= 2) begin : g_rdl
        a_r4_pre_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
            (iss && req_cmd == CMD_PRE && $past(iss && req_cmd == CMD_WR && rst_n))
            |-> (req_bank != $past(req_bank)));
    end

    if (TBDL_CK >= 2) begin : g_bdl
        a_r6_bst_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
            (iss && req_cmd == CMD_BST) |-> !$past(iss && req_cmd == CMD_WR && rst_n));
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_warn
        a_r8_warn_open: assert property (@(posedge clk) disable iff (!rst_n)
            row_age_warn[b] |-> sh_open[b]);
    end
endmodule

bind sdram_cmd_gate sdram_cmd_gate_chk #(
    .NBANK(NBANK), .TCK_PS(TCK_PS), .TRRD_NS(TRRD_NS), .TRFC_NS(TRFC_NS),
    .TRDL_CK(TRDL_CK), .TBDL_CK(TBDL_CK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .ready(ready), .row_age_warn(row_age_warn)
);

// File: tb/sdram_cmd_gate_test.sv
`timescale 1ns/1ps
module sdram_cmd_gate_test;
    localparam int NB  = 4;
    localparam int TCK = 7500;

    function automatic int clocks_of(input int ns);
        return (ns * 1000 + TCK - 1) / TCK;
    endfunction

    localparam int E_RRD = clocks_of(12);
    localparam int E_RCD = clocks_of(18);
    localparam int E_RP  = clocks_of(18);
    localparam int E_RC  = clocks_of(60);
    localparam int E_RAS = clocks_of(42);
    localparam int E_RFC = clocks_of(60);
    localparam int E_CDL = 2;
    localparam int E_RDL = 3;
    localparam int E_BDL = 2;
    localparam int E_WARN_AT = clocks_of(300) - 4;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                           C_PRE = 3'd4, C_REF = 3'd5, C_BST = 3'd6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic ready;
    logic [NB-1:0] row_age_warn;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_cmd_gate #(
        .NBANK(NB), .TCK_PS(TCK), .TRAS_MAX_NS(300), .WARN_CK(4),
        .TCDL_CK(E_CDL), .TRDL_CK(E_RDL), .TBDL_CK(E_BDL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .ready(ready), .row_age_warn(row_age_warn)
    );

    task automatic check(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic probe(input logic [2:0] c, input logic [1:0] b, output logic r);
        req_cmd = c;
        req_bank = b;
        #1;
        r = ready;
    endtask

    task automatic apply_reset();
        req_valid = 1'b0;
        req_cmd = C_NOP;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [2:0] c, input logic [1:0] b);
        req_valid = 1'b1;
        req_cmd = c;
        req_bank = b;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_cmd = C_NOP;
    endtask

    task automatic t_reset_state();
        logic r;
        apply_reset();
        check("R9", "no warning after reset", |row_age_warn, 1'b0);
        probe(C_ACT, 2'd0, r); check("R9", "ACTIVE ready after reset", r, 1'b1);
        probe(C_RD, 2'd0, r);  check("R9", "READ on idle bank", r, 1'b0);
        probe(C_REF, 2'd0, r); check("R5", "REFRESH with all idle", r, 1'b1);
        probe(C_NOP, 2'd3, r); check("R7", "NOP ready with valid low", r, 1'b1);
    endtask

    task automatic t_write_recovery();
        logic r;
        apply_reset();
        issue(C_ACT, 2'd1);
        for (int k = 1; k < E_RAS; k++) begin
            probe(C_WR, 2'd1, r);
            check("R3", $sformatf("WRITE %0d clocks after ACTIVE", k), r, k >= E_RCD);
            next_cycle();
        end
        issue(C_WR, 2'd1);
        probe(C_RD, 2'd1, r);  check("R3", "READ 1 clock after WRITE", r, 1'b0);
        probe(C_BST, 2'd0, r); check("R6", "BST 1 clock after WRITE", r, 1'b0);
        probe(C_PRE, 2'd1, r); check("R4", "PRE 1 clock after WRITE", r, 1'b0);
        next_cycle();
        probe(C_RD, 2'd1, r);  check("R3", "READ 2 clocks after WRITE", r, 1'b1);
        probe(C_BST, 2'd0, r); check("R6", "BST 2 clocks after WRITE", r, 1'b1);
        probe(C_PRE, 2'd1, r); check("R4", "PRE 2 clocks after WRITE", r, 1'b0);
        next_cycle();
        probe(C_PRE, 2'd1, r); check("R4", "PRE 3 clocks after WRITE", r, 1'b1);
        issue(C_PRE, 2'd1);
        probe(C_RD, 2'd1, r);  check("R10", "READ after PRECHARGE", r, 1'b0);
        probe(C_ACT, 2'd1, r); check("R2", "ACTIVE 1 clock after PRE", r, 1'b0);
        next_cycle();
        next_cycle();
        probe(C_ACT, 2'd1, r); check("R2", "ACTIVE tRP after PRE", r, 1'b1);
    endtask

    task automatic t_age_warn();
        apply_reset();
        issue(C_ACT, 2'd2);
        repeat (E_WARN_AT - 2) next_cycle();
        check("R8", "warn one clock early", row_age_warn[2], 1'b0);
        next_cycle();
        check("R8", "warn at threshold", row_age_warn[2], 1'b1);
        check("R8", "other banks quiet", row_age_warn[0] | row_age_warn[1] | row_age_warn[3], 1'b0);
        issue(C_PRE, 2'd2);
        check("R8", "warn cleared by PRECHARGE", row_age_warn[2], 1'b0);
    endtask

    task automatic t_random();
        int t_act[NB], t_pre[NB], t_wr[NB];
        bit open[NB];
        int t_act_any, t_wr_any, t_ref;
        apply_reset();
        for (int b = 0; b < NB; b++) begin
            t_act[b] = -1000; t_pre[b] = -1000; t_wr[b] = -1000; open[b] = 0;
        end
        t_act_any = -1000; t_wr_any = -1000; t_ref = -1000;
        for (int i = 0; i < 4000; i++) begin
            int sel, now, bi;
            logic [2:0] c;
            logic v, r, exp, rfc_ok;
            string tag;
            sel = $urandom_range(15);
            c = (sel < 5) ? C_ACT : (sel < 8) ? C_RD : (sel < 10) ? C_WR :
                (sel < 13) ? C_PRE : (sel == 13) ? C_REF : (sel == 14) ? C_BST : C_NOP;
            bi = $urandom_range(NB - 1);
            v = ($urandom_range(3) != 0);
            probe(c, 2'(bi), r);
            now = cyc;
            rfc_ok = (now - t_ref >= E_RFC);
            exp = 1'b0;
            case (c)
                C_NOP: begin exp = 1'b1; tag = "R7"; end
                C_ACT: begin
                    exp = !open[bi] && (now - t_pre[bi] >= E_RP) && (now - t_act[bi] >= E_RC) &&
                          (now - t_act_any >= E_RRD) && rfc_ok;
                    tag = "R2 R1";
                end
                C_RD, C_WR: begin
                    exp = open[bi] && (now - t_act[bi] >= E_RCD) && (now - t_wr_any >= E_CDL) && rfc_ok;
                    tag = "R3 R10";
                end
                C_PRE: begin
                    exp = (now - t_act[bi] >= E_RAS) && (now - t_wr[bi] >= E_RDL) && rfc_ok;
                    tag = "R4";
                end
                C_REF: begin
                    exp = rfc_ok;
                    for (int b = 0; b < NB; b++)
                        if (open[b] || (now - t_pre[b] < E_RP)) exp = 1'b0;
                    tag = "R5 R11";
                end
                default: begin exp = (now - t_wr_any >= E_BDL) && rfc_ok; tag = "R6"; end
            endcase
            check(tag, $sformatf("random cmd %0d bank %0d cycle %0d", c, bi, now), r, exp);
            req_valid = v;
            if (v && r) begin
                case (c)
                    C_ACT: begin t_act[bi] = now; t_act_any = now; open[bi] = 1; end
                    C_WR:  begin t_wr[bi] = now; t_wr_any = now; end
                    C_PRE: begin t_pre[bi] = now; open[bi] = 0; end
                    C_REF: t_ref = now;
                    default: ;
                endcase
            end
            next_cycle();
            req_valid = 1'b0;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_write_recovery();
        t_age_warn();
        t_random();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule